// File: doc/BRIEF.md
# State-Match Breakpoint with Hashed History

This block is debug logic that sits beside a design under test. Every cycle it sees the design's whole flattened state vector. When a host has armed it, the block stops the design on the first cycle in which that state equals a loaded target. The comparison is exact, apart from the bits the host marks as don't-care. While the design runs, the block also keeps two registers: a copy of the current state, and a short signature. The signature is a programmable universal hash of the state one cycle earlier. After a stop, the pair (captured state, signature) lets an off-chip tool narrow down which state came before. The host can then load that candidate as the next target and run again.

All host access goes through one serial shift path. That path carries the target, the don't-care mask, the hash matrix, the captured state and the signature. The host shifts the full chain length to read every field and to write new values in the same pass. The state vector has no valid/ready pair and cannot apply back-pressure: the design presents a new state every cycle and the block samples it on every clock edge. The control pins are plain single-cycle pulses. The `halt` output is meant to gate the design's clock enable.

Top module: `dbg_bp_top`

## Requirements
- R1: After reset, `halt` is low, the block is not armed, and every bit of the shift chain reads back as zero.
- R2: While `scan_en` is high, each clock edge shifts the chain one place toward `scan_out`. `scan_out` always shows chain bit 0, and `scan_in` enters at the top bit. The chain holds, from bit 0 upward: target (W bits), mask (W), hash matrix (S rows of W, row 0 first), captured state (W), signature (S). Every field is LSB first. Shifting the full chain length writes every field and returns the previous contents.
- R3: A pulse on `arm_set` arms the block only when `halt` is low; a pulse while halted has no effect. Once armed, the block stays armed until a halt occurs.
- R4: When the block is armed, `scan_en` is low, and `dut_state` equals the target on every compared bit, `halt` rises on the next clock edge. Arming is cleared on that same edge.
- R5: When the block is not armed, a state equal to the target never raises `halt`.
- R6: Once high, `halt` stays high until a `halt_clr` pulse, which lowers it on the next edge.
- R7: While `halt` and `scan_en` are both low, each edge loads `dut_state` into the captured-state field. After a halt, that field holds the state that matched. The field does not change while halted.
- R8: On each edge that loads the captured state, signature bit i becomes the XOR of (matrix row i AND the previously captured state). The signature therefore hashes the state one cycle before the captured one. A row with only a few bits set hashes just that chosen subset.
- R9: A mask bit of 1 removes the matching state bit from the comparison. A mask bit of 0 makes that bit count.
- R10: After `halt_clr`, the host can load a new target and arm again without any other action, and the block then stops on the new target.
- R11: While `scan_en` is high, no halt can occur and the captured state and signature are not loaded, even if the state equals the target. Arming is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dut_state | input | STATE_W | Flattened state of the design under test |
| arm_set | input | 1 | Pulse: arm the breakpoint |
| halt_clr | input | 1 | Pulse: release the halt |
| scan_en | input | 1 | Shift the chain one bit this cycle |
| scan_in | input | 1 | Serial data into the chain top |
| scan_out | output | 1 | Serial data from chain bit 0 |
| halt | output | 1 | Stop request to the design under test |

## Verification
If a field is placed wrongly in the chain, or the shift direction is wrong, the fault shows on `scan_out` within one full chain pass. It appears as a value in the wrong bit position when the host reads back what it wrote. A wrong hash row, or a signature taken from the current state instead of the previous one, shows up as a wrong signature field on the first readout after a halt. A fault in the arm or halt control shows on `halt` one edge after the matching state: a stop that is late, missing, or never released. A mask or scan-gating fault shows on that same edge as a halt that should not happen.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;
  // Chain layout from bit 0: target, mask, matrix rows, captured state, signature.
  function automatic int chain_len(input int state_w, input int sig_w);
    return 3 * state_w + sig_w * state_w + sig_w;
  endfunction
  function automatic int cap_lo(input int state_w, input int sig_w);
    return 2 * state_w + sig_w * state_w;
  endfunction
  function automatic int sig_lo(input int state_w, input int sig_w);
    return 3 * state_w + sig_w * state_w;
  endfunction
endpackage

// File: rtl/dbg_bp_hash.sv
module dbg_bp_hash #(
  parameter int STATE_W = 24,
  parameter int SIG_W   = 6
) (
  input  logic [SIG_W*STATE_W-1:0] matrix,
  input  logic [STATE_W-1:0]       state,
  output logic [SIG_W-1:0]         sig
);
  // One parity tree per signature bit, selecting state bits by its row.
  for (genvar i = 0; i < SIG_W; i++) begin : g_row
    assign sig[i] = ^(matrix[i*STATE_W +: STATE_W] & state);
  end
endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
  parameter int STATE_W  = 24,
  parameter bit USE_MASK = 1'b1
) (
  input  logic [STATE_W-1:0] state,
  input  logic [STATE_W-1:0] target,
  input  logic [STATE_W-1:0] dont_care,
  output logic               hit
);
  if (USE_MASK) begin : g_masked
    assign hit = ((state ^ target) & ~dont_care) == '0;
  end else begin : g_exact
    logic unused_mask;
    assign unused_mask = ^dont_care;
    assign hit = (state == target);
  end
endmodule

// File: rtl/dbg_bp_chain.sv
module dbg_bp_chain #(
  parameter int STATE_W = 24,
  parameter int SIG_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic                     scan_in,
  input  logic                     cap_en,
  input  logic [STATE_W-1:0]       cap_d,
  input  logic [SIG_W-1:0]         sig_d,
  output logic [STATE_W-1:0]       target,
  output logic [STATE_W-1:0]       dont_care,
  output logic [SIG_W*STATE_W-1:0] matrix,
  output logic [STATE_W-1:0]       cap_q,
  output logic [SIG_W-1:0]         sig_q,
  output logic                     scan_out
);
  localparam int TOT    = dbg_bp_pkg::chain_len(STATE_W, SIG_W);
  localparam int MSK_LO = STATE_W;
  localparam int MAT_LO = 2 * STATE_W;
  localparam int CAP_LO = dbg_bp_pkg::cap_lo(STATE_W, SIG_W);
  localparam int SIG_LO = dbg_bp_pkg::sig_lo(STATE_W, SIG_W);

  logic [TOT-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= {scan_in, chain_q[TOT-1:1]};
    end else if (cap_en) begin
      chain_q[CAP_LO +: STATE_W] <= cap_d;
      chain_q[SIG_LO +: SIG_W]   <= sig_d;
    end
  end

  assign target    = chain_q[0 +: STATE_W];
  assign dont_care = chain_q[MSK_LO +: STATE_W];
  assign matrix    = chain_q[MAT_LO +: SIG_W*STATE_W];
  assign cap_q     = chain_q[CAP_LO +: STATE_W];
  assign sig_q     = chain_q[SIG_LO +: SIG_W];
  assign scan_out  = chain_q[0];

  // R7: history registers frozen when neither shifting nor capturing
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !cap_en) |=> ($stable(cap_q) && $stable(sig_q)));
  // R2: a shift moves the old bit 1 down to the output
  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (scan_out == $past(chain_q[1])));
endmodule

// File: rtl/dbg_bp_top.sv
module dbg_bp_top #(
  parameter int STATE_W  = 24,
  parameter int SIG_W    = 6,
  parameter bit USE_MASK = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] dut_state,
  input  logic               arm_set,
  input  logic               halt_clr,
  input  logic               scan_en,
  input  logic               scan_in,
  output logic               scan_out,
  output logic               halt
);
  logic [STATE_W-1:0]       target, dont_care, cap_q;
  logic [SIG_W*STATE_W-1:0] matrix;
  logic [SIG_W-1:0]         sig_q, sig_d;
  logic                     hit, fire, cap_en;
  logic                     armed_q, halt_q;

  assign cap_en = !halt_q && !scan_en;
  assign fire   = armed_q && hit && !scan_en;

  dbg_bp_chain #(.STATE_W(STATE_W), .SIG_W(SIG_W)) chain_i (
    .clk(clk), .rst_n(rst_n), .shift_en(scan_en), .scan_in(scan_in),
    .cap_en(cap_en), .cap_d(dut_state), .sig_d(sig_d),
    .target(target), .dont_care(dont_care), .matrix(matrix),
    .cap_q(cap_q), .sig_q(sig_q), .scan_out(scan_out)
  );

  // Hash the previously captured state so the signature lags by one cycle.
  dbg_bp_hash #(.STATE_W(STATE_W), .SIG_W(SIG_W)) hash_i (
    .matrix(matrix), .state(cap_q), .sig(sig_d)
  );

  dbg_bp_match #(.STATE_W(STATE_W), .USE_MASK(USE_MASK)) match_i (
    .state(dut_state), .target(target), .dont_care(dont_care), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      if (fire) begin
        halt_q  <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        if (halt_clr) halt_q <= 1'b0;
        if (arm_set && !halt_q) armed_q <= 1'b1;
      end
    end
  end

  assign halt = halt_q;

  // R4: armed match outside scan stops the design next edge and disarms
  a_r4_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && hit && !scan_en) |=> (halt_q && !armed_q));
  // R5: a halt only ever follows an armed cycle
  a_r5_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_q) |-> $past(armed_q));
  // R6: halt persists until cleared
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !halt_clr) |=> halt_q);
  // R3: never armed while halted
  a_r3_arm_excl: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> !halt_q);
  // R11: shifting never starts a halt
  a_r11_scan_block: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !halt_q) |=> !halt_q);
endmodule

// File: tb/dbg_bp_top_tb_top.sv
module dbg_bp_top_tb_top;
  localparam int W      = 24;
  localparam int S      = 6;
  localparam int TOT    = 3 * W + S * W + S;
  localparam int CLK_P  = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic         rst_n = 1'b0;
  logic [W-1:0] dut_state = '0;
  logic         arm_set = 1'b0, halt_clr = 1'b0, scan_en = 1'b0, scan_in = 1'b0;
  logic         scan_out, halt;

  dbg_bp_top #(.STATE_W(W), .SIG_W(S), .USE_MASK(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .dut_state(dut_state), .arm_set(arm_set),
    .halt_clr(halt_clr), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .halt(halt)
  );

  // Reference model state
  logic [W-1:0]   tgt_m = '0, msk_m = '0, cap_m = '0;
  logic [S*W-1:0] mat_m = '0;
  logic [S-1:0]   sig_m = '0;
  bit             halt_m = 0, armed_m = 0;
  int             total = 0, bad = 0;
  bit             done = 0;
  string          halt_tag = "R1";
  bit             exp_q[$];
  string          tag_q[$];

  function automatic logic [S-1:0] ref_hash(logic [S*W-1:0] m, logic [W-1:0] s);
    logic [S-1:0] r = '0;
    for (int i = 0; i < S; i++)
      for (int j = 0; j < W; j++)
        r[i] = r[i] ^ (m[i*W + j] & s[j]);
    return r;
  endfunction

  function automatic logic [TOT-1:0] pack(logic [W-1:0] t, logic [W-1:0] k,
      logic [S*W-1:0] m, logic [W-1:0] c, logic [S-1:0] g);
    return {g, c, m, k, t};
  endfunction

  function automatic string field_tag(int k);
    if (k < 2*W + S*W) return "R2";
    if (k < 3*W + S*W) return "R7";
    return "R8";
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_model(logic [W-1:0] st, bit a, bit c, bit sen);
    bit hit, fire, h_old;
    hit   = ((st ^ tgt_m) & ~msk_m) == '0;
    fire  = armed_m && hit && !sen;
    h_old = halt_m;
    if (!sen && !h_old) begin
      sig_m = ref_hash(mat_m, cap_m);
      cap_m = st;
    end
    if (fire) begin
      halt_m = 1; armed_m = 0;
    end else begin
      if (c) halt_m = 0;
      if (a && !h_old) armed_m = 1;
    end
  endtask

  // Driver: called at posedge+1, returns at posedge+1
  task automatic step(logic [W-1:0] st, bit a, bit c);
    dut_state = st; arm_set = a; halt_clr = c; scan_en = 0;
    @(posedge clk);
    edge_model(st, a, c, 0);
    #1;
    arm_set = 0; halt_clr = 0;
  endtask

  task automatic xfer(logic [TOT-1:0] nv, string ovr, logic [W-1:0] st_scan);
    logic [TOT-1:0] old;
    old = pack(tgt_m, msk_m, mat_m, cap_m, sig_m);
    dut_state = st_scan;
    for (int k = 0; k < TOT; k++) begin
      scan_en = 1; scan_in = nv[k];
      exp_q.push_back(old[k]);
      tag_q.push_back(ovr != "" ? ovr : field_tag(k));
      @(posedge clk);
      edge_model(dut_state, 0, 0, 1);
      #1;
    end
    scan_en = 0;
    {sig_m, cap_m, mat_m, msk_m, tgt_m} = nv;
  endtask

  // Monitor: compares serial output and halt against the model at negedge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0) begin
        bit e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(scan_out === e, t, {31'd0, scan_out}, {31'd0, e});
      end
      chk(halt === halt_m, halt_tag, {31'd0, halt}, {31'd0, halt_m});
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [S*W-1:0] mat;
    logic [W-1:0] t1, t2;
    t1 = 24'hA53C71; t2 = 24'h3C0F81;
    for (int i = 0; i < S; i++) begin
      logic [W-1:0] row;
      row = (24'h9E3779 >> i) ^ (24'h5A5A5A << i);
      if (i == S - 1) row = 24'h0000F0; // subset row (R8)
      mat[i*W +: W] = row;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state, then chain reads zero while loading the setup
    halt_tag = "R1";
    chk(halt === 1'b0, "R1", {31'd0, halt}, 32'd0);
    xfer(pack(t1, '0, mat, '0, '0), "R1", 24'h000000);
    // R2: read back exactly what was written, in field order
    halt_tag = "R2";
    xfer(pack(t1, '0, mat, 24'h0F0F0F, 6'h2A), "", 24'h000000);
    // R5: target reached while not armed
    halt_tag = "R5";
    step(24'h123456, 0, 0); step(24'h00FF00, 0, 0);
    step(t1, 0, 0); step(24'h777777, 0, 0);
    // R4: armed, halt on the cycle after the match
    halt_tag = "R4";
    step(24'h010203, 1, 0); step(24'hC0FFEE, 0, 0); step(24'hBEEF01, 0, 0);
    step(t1, 0, 0);
    // R6: halt held with differing state
    halt_tag = "R6";
    step(24'h111111, 0, 0); step(24'h222222, 0, 0);
    // R7/R8: captured state is t1, signature hashes the state before it
    chk(cap_m == t1, "R7", {8'd0, cap_m}, {8'd0, t1});
    chk(sig_m == ref_hash(mat, 24'hBEEF01), "R8", {26'd0, sig_m},
        {26'd0, ref_hash(mat, 24'hBEEF01)});
    xfer(pack(tgt_m, msk_m, mat_m, cap_m, sig_m), "", 24'h333333);
    // R3: arm while halted is ignored
    halt_tag = "R3";
    step(24'h444444, 1, 0);
    step(24'h444444, 0, 1);
    step(t1, 0, 0); step(24'h555555, 0, 0);
    // R9: mask low byte out of the comparison
    halt_tag = "R9";
    xfer(pack(t2, 24'h0000FF, mat, cap_m, sig_m), "", 24'h555555);
    step(24'h666666, 1, 0);
    step(t2 ^ 24'h000100, 0, 0);
    step(t2 ^ 24'h00005A, 0, 0);
    step(24'h000001, 0, 0);
    // R10: clear, re-arm, exact new target
    halt_tag = "R10";
    xfer(pack(t2, '0, mat, cap_m, sig_m), "", 24'h000001);
    step(24'h000002, 0, 1);
    step(24'h000003, 1, 0);
    step(t2, 0, 0); step(24'h000004, 0, 0);
    // R11: scan blocks a match, arming survives the pass
    halt_tag = "R11";
    step(24'h000005, 0, 1);
    step(24'h000006, 1, 0);
    xfer(pack(t2, '0, mat, cap_m, sig_m), "", t2);
    step(t2, 0, 0); step(24'h000007, 0, 0);
    xfer(pack(t1, '0, mat, cap_m, sig_m), "", 24'h000007);
    repeat (2) @(posedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule